// File: doc/BRIEF.md
# Serial Debug Command Controller

This block is the slave end of a bit-serial debug link into a processor core. A host raises a request line to halt the core. The block waits until the core reports that its current instruction has finished. It then pulses a strobe so the core saves its pipeline, enters debug mode and drives an acknowledge level on the serial output. Once the host drops the request, it shifts 8-bit commands in, most significant bit first, on rising edges of its own serial clock. The serial clock, serial data and request lines are all brought into the system clock domain through two-flop synchronisers, and the edges are found there.

Each command has four fields. Bit 7 selects read (1) or write (0). Bit 6 is GO and bit 5 is EX. Bits 4..0 name one of five 16-bit debug registers (control/status, breakpoint counter, trace counter, upper and lower address limit), or one of two clear actions, or nothing. A write is followed by 16 data bits. A read shifts the selected register out on the serial output over the next 16 serial clocks. GO resumes the core once the command has finished. If EX is also set, the core leaves debug mode for good; if not, the core returns to debug mode after one step. Raising and releasing the request while in debug mode throws away a partial command and acknowledges again, so a host that has lost count can recover.

Top module: `dbg_serial_port`

## Requirements
- R1: With the request high outside debug mode, the block waits for `core_done_i`, raises `save_pipe_o` in that same cycle, and has `debug_mode_o` high from the next cycle on. `debug_mode_o` stays low until then.
- R2: On entering debug mode, `sdo_o` is 1 for as long as the request stays high. After the request is released, `sdo_o` is 0 while the block waits for command bits.
- R3: A request pulse in debug mode discards any partly received command and drives `sdo_o` to 1 while the request is high. The next full command after release is decoded correctly.
- R4: `wake_o` goes high within 3 system clocks of the request going high and low again within 3 clocks of its release.
- R5: Commands are 8 bits, sampled on rising serial clock edges MSB first: bit 7 read(1)/write(0), bit 6 GO, bit 5 EX, bits 4..0 select.
- R6: Select codes 00000 control/status, 00001 breakpoint counter, 00011 trace counter, 00110 upper limit and 00111 lower limit name 16-bit registers. A write command with one of them loads the next 16 serial bits, MSB first, into that register.
- R7: A read command with one of those codes presents the register on `sdo_o` MSB first. Each bit is valid before the next rising serial clock, over 16 clocks.
- R8: Code 01100 zeroes the breakpoint counter and code 01110 zeroes the trace counter. Neither has a data phase, and no other register changes.
- R9: Code 11111 and every other unlisted code cause no register change and no data phase, whether read or write.
- R10: A completed command with GO set gives a one-cycle `resume_o` pulse. With EX also set, `debug_mode_o` falls and stays low while the request is low.
- R11: With GO set and EX clear, `debug_mode_o` falls and returns high after the next `core_done_i` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| dbg_req_i | input | 1 | Asynchronous debug request from host |
| sck_i | input | 1 | Asynchronous serial clock from host |
| sdi_i | input | 1 | Serial data from host |
| core_done_i | input | 1 | Core finished its current instruction or step |
| sdo_o | output | 1 | Serial output: acknowledge level or read data |
| wake_o | output | 1 | Forces core out of stop/wait states |
| save_pipe_o | output | 1 | Strobe telling the core to save pipeline state |
| debug_mode_o | output | 1 | Core is halted in debug mode |
| resume_o | output | 1 | One-cycle pulse releasing the core |

## Verification
A host-side serial edge reaches the state register three system clocks later: two synchroniser stages, then the edge register. The bench therefore holds each serial clock phase for five system clocks and samples read data from `sdo_o` at the end of the low phase, just before it raises the clock. `save_pipe_o` is combinational from the halt state and `core_done_i`, so it is checked one nanosecond after the driving negedge. `resume_o`, the clear actions and register writes take effect one clock after the final serial edge is detected. They are therefore checked once the five-clock high phase of that bit has passed, with pulses counted by a clocked monitor.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    localparam int CMD_W = 8;

    localparam logic [4:0] SEL_CTRL  = 5'b00000;
    localparam logic [4:0] SEL_BPC   = 5'b00001;
    localparam logic [4:0] SEL_TRC   = 5'b00011;
    localparam logic [4:0] SEL_LIMHI = 5'b00110;
    localparam logic [4:0] SEL_LIMLO = 5'b00111;
    localparam logic [4:0] SEL_CLBPC = 5'b01100;
    localparam logic [4:0] SEL_CLTRC = 5'b01110;

    typedef enum logic [2:0] {
        ST_RUN, ST_HALT, ST_ACK, ST_CMD, ST_RD, ST_WR, ST_STEP
    } dbg_state_e;

    typedef enum logic [2:0] {
        RG_CTRL, RG_BPC, RG_TRC, RG_LIMHI, RG_LIMLO
    } reg_id_e;

    localparam int NREG = 5;

    typedef struct packed {
        logic    rd;
        logic    go;
        logic    ex;
        logic    acc;
        reg_id_e id;
        logic    clr_bpc;
        logic    clr_trc;
    } cmd_dec_t;

endpackage

// File: rtl/dbg_sync.sv
module dbg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
    import dbg_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_i,
    output cmd_dec_t         dec_o
);
    logic [4:0] sel;
    assign sel = cmd_i[4:0];

    always_comb begin
        dec_o         = '0;
        dec_o.rd      = cmd_i[7];
        dec_o.go      = cmd_i[6];
        dec_o.ex      = cmd_i[5];
        dec_o.id      = RG_CTRL;
        case (sel)
            SEL_CTRL:  begin dec_o.acc = 1'b1; dec_o.id = RG_CTRL;  end
            SEL_BPC:   begin dec_o.acc = 1'b1; dec_o.id = RG_BPC;   end
            SEL_TRC:   begin dec_o.acc = 1'b1; dec_o.id = RG_TRC;   end
            SEL_LIMHI: begin dec_o.acc = 1'b1; dec_o.id = RG_LIMHI; end
            SEL_LIMLO: begin dec_o.acc = 1'b1; dec_o.id = RG_LIMLO; end
            SEL_CLBPC: dec_o.clr_bpc = 1'b1;
            SEL_CLTRC: dec_o.clr_trc = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/dbg_regfile.sv
module dbg_regfile
    import dbg_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  reg_id_e           wr_id_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              clr_bpc_i,
    input  logic              clr_trc_i,
    input  reg_id_e           rd_id_i,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [DATA_W-1:0] regs_d [NREG];
    logic [DATA_W-1:0] regs_q [NREG];

    always_comb begin
        regs_d = regs_q;
        if (wr_en_i)   regs_d[wr_id_i] = wr_data_i;
        if (clr_bpc_i) regs_d[RG_BPC]  = '0;
        if (clr_trc_i) regs_d[RG_TRC]  = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_data_o = regs_q[rd_id_i];

    // R8
    clr_bpc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_bpc_i |=> (regs_q[RG_BPC] == '0));

    // R8
    clr_trc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_trc_i |=> (regs_q[RG_TRC] == '0));

    // R6
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !clr_bpc_i && !clr_trc_i) |=> (regs_q[$past(wr_id_i)] == $past(wr_data_i)));
endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port
    import dbg_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dbg_req_i,
    input  logic sck_i,
    input  logic sdi_i,
    input  logic core_done_i,
    output logic sdo_o,
    output logic wake_o,
    output logic save_pipe_o,
    output logic debug_mode_o,
    output logic resume_o
);
    localparam int CNT_W = (DATA_W > CMD_W) ? $clog2(DATA_W) : $clog2(CMD_W);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        dbg_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [CMD_W-1:0]  cmd;
        logic [DATA_W-1:0] dsh;
        logic              resume;
        logic              sck_prev;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [2:0]        sync_s;
    logic              req_s, sck_s, sdi_s, sck_rise;
    logic [CMD_W-1:0]  cmd_next, dec_in;
    cmd_dec_t          dec;
    logic              wr_en, clr_bpc, clr_trc, fin;
    logic [DATA_W-1:0] wr_data, rd_data;

    dbg_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({dbg_req_i, sck_i, sdi_i}),
        .q_o   (sync_s)
    );
    assign {req_s, sck_s, sdi_s} = sync_s;
    assign sck_rise = sck_s & ~ctl_q.sck_prev;
    assign cmd_next = {ctl_q.cmd[CMD_W-2:0], sdi_s};
    assign dec_in   = (ctl_q.st == ST_CMD) ? cmd_next : ctl_q.cmd;

    dbg_cmd_decode i_dec (
        .cmd_i (dec_in),
        .dec_o (dec)
    );

    dbg_regfile #(.DATA_W(DATA_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_id_i   (dec.id),
        .wr_data_i (wr_data),
        .clr_bpc_i (clr_bpc),
        .clr_trc_i (clr_trc),
        .rd_id_i   (dec.id),
        .rd_data_o (rd_data)
    );

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.resume   = 1'b0;
        ctl_d.sck_prev = sck_s;
        wr_en          = 1'b0;
        wr_data        = {ctl_q.dsh[DATA_W-2:0], sdi_s};
        clr_bpc        = 1'b0;
        clr_trc        = 1'b0;
        fin            = 1'b0;
        save_pipe_o    = 1'b0;

        case (ctl_q.st)
            ST_RUN: begin
                if (req_s) ctl_d.st = ST_HALT;
            end
            ST_HALT: begin
                if (core_done_i) begin
                    save_pipe_o = 1'b1;
                    ctl_d.st    = ST_ACK;
                    ctl_d.cnt   = '0;
                    ctl_d.cmd   = '0;
                end
            end
            ST_ACK: begin
                if (!req_s) begin
                    ctl_d.st  = ST_CMD;
                    ctl_d.cnt = '0;
                end
            end
            default: begin
                if (req_s) begin
                    ctl_d.st  = ST_ACK;
                    ctl_d.cnt = '0;
                    ctl_d.cmd = '0;
                end else begin
                    case (ctl_q.st)
                        ST_CMD: if (sck_rise) begin
                            ctl_d.cmd = cmd_next;
                            if (ctl_q.cnt == CMD_LAST) begin
                                ctl_d.cnt = '0;
                                if (dec.acc) begin
                                    if (dec.rd) begin
                                        ctl_d.dsh = rd_data;
                                        ctl_d.st  = ST_RD;
                                    end else begin
                                        ctl_d.st  = ST_WR;
                                    end
                                end else begin
                                    clr_bpc = dec.clr_bpc;
                                    clr_trc = dec.clr_trc;
                                    fin     = 1'b1;
                                end
                            end else begin
                                ctl_d.cnt = ctl_q.cnt + 1'b1;
                            end
                        end
                        ST_RD: if (sck_rise) begin
                            ctl_d.dsh = {ctl_q.dsh[DATA_W-2:0], 1'b0};
                            if (ctl_q.cnt == DATA_LAST) fin = 1'b1;
                            else ctl_d.cnt = ctl_q.cnt + 1'b1;
                        end
                        ST_WR: if (sck_rise) begin
                            ctl_d.dsh = wr_data;
                            if (ctl_q.cnt == DATA_LAST) begin
                                wr_en = 1'b1;
                                fin   = 1'b1;
                            end else begin
                                ctl_d.cnt = ctl_q.cnt + 1'b1;
                            end
                        end
                        ST_STEP: if (core_done_i) ctl_d.st = ST_ACK;
                        default: ctl_d.st = ST_RUN;
                    endcase

                    if (fin) begin
                        ctl_d.cnt = '0;
                        if (dec.go) begin
                            ctl_d.resume = 1'b1;
                            ctl_d.st     = dec.ex ? ST_RUN : ST_STEP;
                        end else begin
                            ctl_d.st     = ST_CMD;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_RUN;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign wake_o       = req_s;
    assign resume_o     = ctl_q.resume;
    assign debug_mode_o = (ctl_q.st == ST_ACK) || (ctl_q.st == ST_CMD) ||
                          (ctl_q.st == ST_RD)  || (ctl_q.st == ST_WR);
    assign sdo_o        = (ctl_q.st == ST_ACK) ||
                          ((ctl_q.st == ST_RD) && ctl_q.dsh[DATA_W-1]);

    // R1
    save_then_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_pipe_o |=> debug_mode_o);

    // R2
    entry_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(debug_mode_o) |-> sdo_o);

    // R10
    resume_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |=> !resume_o);

    // R10
    resume_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |-> !debug_mode_o);

    // R9
    decode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dec.acc, dec.clr_bpc, dec.clr_trc}));

    // R5
    cmd_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_CMD) |-> (ctl_q.cnt <= CMD_LAST));
endmodule

// File: tb/test_dbg_serial_port.sv
module test_dbg_serial_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dbg_req_i = 1'b0, sck_i = 1'b0, sdi_i = 1'b0, core_done_i = 1'b0;
    logic sdo_o, wake_o, save_pipe_o, debug_mode_o, resume_o;

    int n_tests = 0, n_fail = 0, n_resume = 0;
    bit done = 1'b0;
    logic [15:0] mdl [5];

    always #10 clk = ~clk;

    dbg_serial_port i_dbg_serial_port (
        .clk(clk), .rst_n(rst_n), .dbg_req_i(dbg_req_i), .sck_i(sck_i),
        .sdi_i(sdi_i), .core_done_i(core_done_i), .sdo_o(sdo_o), .wake_o(wake_o),
        .save_pipe_o(save_pipe_o), .debug_mode_o(debug_mode_o), .resume_o(resume_o)
    );

    always @(posedge clk) if (resume_o) n_resume++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int idx(input logic [4:0] sel);
        case (sel)
            5'b00000: return 0;
            5'b00001: return 1;
            5'b00011: return 2;
            5'b00110: return 3;
            5'b00111: return 4;
            default:  return -1;
        endcase
    endfunction

    function automatic logic [4:0] code_of(input int i);
        case (i)
            0: return 5'b00000;
            1: return 5'b00001;
            2: return 5'b00011;
            3: return 5'b00110;
            default: return 5'b00111;
        endcase
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk); sdi_i = b; sck_i = 1'b0;
        repeat (5) @(negedge clk);
        sck_i = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic recv_bit(output logic b);
        @(negedge clk); sck_i = 1'b0;
        repeat (5) @(negedge clk);
        b = sdo_o;
        sck_i = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic send_cmd(input logic rd, input logic go, input logic ex, input logic [4:0] sel);
        logic [7:0] c;
        c = {rd, go, ex, sel};
        for (int i = 7; i >= 0; i--) send_bit(c[i]);
    endtask

    task automatic wr_reg(input logic [4:0] sel, input logic [15:0] v);
        send_cmd(1'b0, 1'b0, 1'b0, sel);
        for (int i = 15; i >= 0; i--) send_bit(v[i]);
        if (idx(sel) >= 0) mdl[idx(sel)] = v;
    endtask

    task automatic rd_reg(input logic [4:0] sel, output logic [15:0] v);
        send_cmd(1'b1, 1'b0, 1'b0, sel);
        for (int i = 15; i >= 0; i--) begin
            logic b;
            recv_bit(b);
            v[i] = b;
        end
    endtask

    task automatic check_all(input string req);
        logic [15:0] v;
        for (int i = 0; i < 5; i++) begin
            rd_reg(code_of(i), v);
            chk(req, {16'h0, v}, {16'h0, mdl[i]});
        end
    endtask

    function automatic logic [4:0] pick_reserved();
        logic [4:0] s;
        do s = 5'($urandom_range(0, 31));
        while (idx(s) >= 0 || s == 5'b01100 || s == 5'b01110);
        return s;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int r0;
        void'($urandom(32'h1234abcd));
        for (int i = 0; i < 5; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("reset debug_mode", {31'h0, debug_mode_o}, 0);
        chk("reset sdo", {31'h0, sdo_o}, 0);
        chk("reset resume", {31'h0, resume_o}, 0);
        chk("reset wake", {31'h0, wake_o}, 0);

        // R4 and R1: request, core not yet done
        dbg_req_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R4 wake high", {31'h0, wake_o}, 1);
        repeat (3) @(negedge clk);
        chk("R1 not halted before done", {31'h0, debug_mode_o}, 0);
        core_done_i = 1'b1;
        #1 chk("R1 save strobe", {31'h0, save_pipe_o}, 1);
        @(negedge clk); core_done_i = 1'b0;
        chk("R1 debug mode", {31'h0, debug_mode_o}, 1);
        repeat (4) @(negedge clk);
        chk("R2 ack level", {31'h0, sdo_o}, 1);
        dbg_req_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 wake low", {31'h0, wake_o}, 0);
        repeat (2) @(negedge clk);
        chk("R2 sdo low awaiting cmd", {31'h0, sdo_o}, 0);

        // R5 R6 R7 directed writes and reads
        wr_reg(5'b00000, 16'hFFFF);
        wr_reg(5'b00001, 16'h8001);
        wr_reg(5'b00011, 16'h0000);
        wr_reg(5'b00110, 16'hA5C3);
        wr_reg(5'b00111, 16'h1234);
        check_all("R6 R7 directed");

        // R8 clears
        wr_reg(5'b00011, 16'h7E7E);
        send_cmd(1'b0, 1'b0, 1'b0, 5'b01100); mdl[1] = '0;
        check_all("R8 clear bpc");
        send_cmd(1'b1, 1'b0, 1'b0, 5'b01110); mdl[2] = '0;
        check_all("R8 clear trc");

        // R9 reserved and no-register codes
        r0 = n_resume;
        send_cmd(1'b0, 1'b0, 1'b0, 5'b11111);
        send_cmd(1'b1, 1'b0, 1'b0, 5'b11111);
        send_cmd(1'b0, 1'b0, 1'b0, 5'b00010);
        send_cmd(1'b1, 1'b0, 1'b0, 5'b01101);
        send_cmd(1'b0, 1'b0, 1'b0, 5'b10011);
        check_all("R9 reserved no effect");
        chk("R9 no resume", n_resume, r0);
        chk("R9 still debug", {31'h0, debug_mode_o}, 1);

        // R3 resync mid-command
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        @(negedge clk); dbg_req_i = 1'b1;
        repeat (5) @(negedge clk);
        chk("R3 re-ack", {31'h0, sdo_o}, 1);
        dbg_req_i = 1'b0;
        repeat (5) @(negedge clk);
        rd_reg(5'b00110, v);
        chk("R3 read after resync", {16'h0, v}, {16'h0, mdl[3]});

        // random mix
        for (int it = 0; it < 40; it++) begin
            int k;
            int ri;
            k  = $urandom_range(0, 9);
            ri = $urandom_range(0, 4);
            if (k <= 3) begin
                wr_reg(code_of(ri), 16'($urandom));
            end else if (k <= 6) begin
                rd_reg(code_of(ri), v);
                chk("R7 random read", {16'h0, v}, {16'h0, mdl[ri]});
            end else if (k == 7) begin
                if (ri[0]) begin send_cmd(1'b0, 1'b0, 1'b0, 5'b01100); mdl[1] = '0; end
                else       begin send_cmd(1'b0, 1'b0, 1'b0, 5'b01110); mdl[2] = '0; end
            end else begin
                send_cmd(1'($urandom_range(0, 1)), 1'b0, 1'b0, pick_reserved());
            end
        end
        check_all("R6 R8 R9 random final");

        // R11 GO without EX
        r0 = n_resume;
        send_cmd(1'b0, 1'b1, 1'b0, 5'b11111);
        chk("R11 resume pulse", n_resume, r0 + 1);
        chk("R11 core released", {31'h0, debug_mode_o}, 0);
        core_done_i = 1'b1;
        @(negedge clk); core_done_i = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 back in debug", {31'h0, debug_mode_o}, 1);
        rd_reg(5'b00000, v);
        chk("R11 read after step", {16'h0, v}, {16'h0, mdl[0]});

        // R10 GO with EX after a write
        r0 = n_resume;
        send_cmd(1'b0, 1'b1, 1'b1, 5'b00111);
        for (int i = 15; i >= 0; i--) send_bit(1'(16'h0F0F >> i));
        mdl[4] = 16'h0F0F;
        chk("R10 resume pulse", n_resume, r0 + 1);
        chk("R10 exit debug", {31'h0, debug_mode_o}, 0);
        core_done_i = 1'b1;
        repeat (3) @(negedge clk); core_done_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 stays running", {31'h0, debug_mode_o}, 0);

        // re-enter and confirm the written value
        dbg_req_i = 1'b1;
        repeat (5) @(negedge clk);
        core_done_i = 1'b1;
        @(negedge clk); core_done_i = 1'b0;
        chk("R1 re-entry", {31'h0, debug_mode_o}, 1);
        dbg_req_i = 1'b0;
        repeat (5) @(negedge clk);
        rd_reg(5'b00111, v);
        chk("R10 write before exit", {16'h0, v}, 32'h0F0F);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule